// File: doc/BRIEF.md
# Mask-Controlled Partitioned Lane Adder

This block adds two W-bit operands in a single combinational pass. The adder is cut into independent narrower lanes while it runs. The candidate cut points are evenly spaced every M bits, where M is the width of the lane-select input `lane_cut`. Bit i of `lane_cut` opens a cut at bit position (i+1)·M. At an open cut, the carry leaving the lower lane is dropped and the upper lane starts with a carry-in of zero. At a closed cut, the carry ripples on as in an ordinary wide add. The top bit of `lane_cut` is never used, because no cut lies at or above W.

With the default sizes (W = 16, M = 4), a cut pattern of zero gives one 16-bit add. The pattern 0b0010 gives two 8-bit adds, and 0b1111 gives four 4-bit adds. Mixed patterns are legal and give lanes of unequal width. For example, 0b0001 gives a 4-bit lane with a 12-bit lane above it. Each lane wraps modulo two to the power of its width. There is no saturation and no carry-out flag. The cut pattern may change on any cycle, because the block holds no state.

Top module: `part_mask_adder`

## Requirements
- R1: When no cut is open (all `lane_cut` bits below the top bit are zero), `sum` equals (a + b) mod 2^W.
- R2: Cut positions are bit M, 2M, 3M and so on, strictly below W. `lane_cut` bit i controls the cut at bit (i+1)·M. For W = 16 and M = 4, bits 0, 1 and 2 control cuts at bits 4, 8 and 12.
- R3: At an open cut, no carry enters the upper lane. The bits of the upper lane depend only on the operand bits of that lane.
- R4: At a closed cut, the carry from the bits below passes upward, exactly as in a full-width add.
- R5: Each lane's result wraps modulo 2^(lane width), and the carry out of the lane is discarded.
- R6: The most significant bit of `lane_cut` has no effect on `sum`.
- R7: Mixed cut patterns give lanes of unequal width. For example, 0b0001 gives a 4-bit lane at bits 3:0 and a 12-bit lane at bits 15:4.
- R8: The block is purely combinational. `sum` follows any change of `a`, `b` or `lane_cut` without waiting for a clock edge and carries no history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First addend |
| b | input | W | Second addend |
| lane_cut | input | M | Bit i opens the lane cut at bit (i+1)·M; the top bit is unused |
| sum | output | W | Lane-wise sum, with the carry out of each lane dropped |

## Verification
A fixed table pairs specific cut patterns with operands whose carries would cross one particular boundary. This shows whether each cut blocks or passes a carry at the correct bit position, and it separates a full-width result from a partitioned one. Patterns that set only the top bit, or that join it to other bits, must give the same sum as the same pattern without it. This separates an unused top bit from one that is wrongly wired to a cut. A sweep over all sixteen patterns compares the output with a lane-by-lane reference model. The sweep uses all-ones plus one at each lane bottom, alternating bit patterns and carry-free sums, so it tells apart a carry leak, a missed ripple and a cut at the wrong position. Changing the pattern while the operands stay fixed shows that the output tracks the current pattern with no history.

// File: rtl/part_mask_adder.sv
module part_mask_adder #(
  parameter int W = 16,
  parameter int M = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [M-1:0] lane_cut,
  output logic [W-1:0] sum
);
  localparam int NSEG = (W + M - 1) / M;
  localparam logic [M-1:0] CUT_USED = M'((1 << (NSEG - 1)) - 1);

  if (M < 1 || M > W || NSEG > M) begin : g_bad_cfg
    $error("part_mask_adder: need 1 <= M <= W and ceil(W/M) <= M");
  end

  logic [NSEG-1:0] seg_co;
  logic            unused_cut_bits;
  assign unused_cut_bits = ^lane_cut[M-1:NSEG-1];

  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    localparam int LO = j * M;
    localparam int SW = (W - LO < M) ? (W - LO) : M;
    localparam int HI = LO + SW - 1;
    localparam logic [M-1:0] BELOW = M'((1 << j) - 1);
    logic cin;

    if (j == 0) begin : g_first
      assign cin = 1'b0;
    end else begin : g_link
      assign cin = seg_co[j-1] & ~lane_cut[j-1];
    end

    if (j == NSEG - 1) begin : g_top
      assign sum[HI:LO] = a[HI:LO] + b[HI:LO] + SW'(cin);
      assign seg_co[j]  = 1'b0;
    end else begin : g_mid
      assign {seg_co[j], sum[HI:LO]} =
        (SW+1)'(a[HI:LO]) + (SW+1)'(b[HI:LO]) + (SW+1)'(cin);
    end

    always_comb begin
      if ((lane_cut & BELOW) == '0) begin
        assert_carry_ripple_R4: assert (sum[HI:0] == a[HI:0] + b[HI:0])
          else $error("R4: bits %0d:0 differ from plain add", HI);
      end
    end

    if (j > 0) begin : g_iso
      always_comb begin
        if (lane_cut[j-1]) begin
          assert_lane_isolated_R3: assert (sum[HI:LO] == a[HI:LO] + b[HI:LO])
            else $error("R3: carry leaked across cut at bit %0d", LO);
        end
      end
    end
  end

  always_comb begin
    if ((lane_cut & CUT_USED) == '0) begin
      assert_full_width_R1: assert (sum == a + b)
        else $error("R1: full-width sum wrong");
    end
  end

  always_comb begin
    if (!$isunknown({a, b, lane_cut})) begin
      assert_known_out_R8: assert (!$isunknown(sum))
        else $error("R8: output unknown for known inputs");
    end
  end
endmodule

// File: tb/part_mask_adder_test.sv
module part_mask_adder_test;
  localparam int W = 16;
  localparam int M = 4;

  typedef struct packed {
    logic [3:0]   req;
    logic [M-1:0] cut;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] y;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 4'b0000, 16'hFFFF, 16'h0001, 16'h0000}, // R1
    '{4'd1, 4'b0000, 16'h1234, 16'h1111, 16'h2345}, // R1
    '{4'd3, 4'b0010, 16'h00FF, 16'h0001, 16'h0000}, // R3
    '{4'd5, 4'b0010, 16'hFF00, 16'h0100, 16'h0000}, // R5
    '{4'd3, 4'b1111, 16'hFFFF, 16'h1111, 16'h0000}, // R3
    '{4'd3, 4'b1111, 16'h1234, 16'h4321, 16'h5555}, // R3
    '{4'd7, 4'b0001, 16'h000F, 16'h0001, 16'h0000}, // R7
    '{4'd7, 4'b0001, 16'hFFF0, 16'h0010, 16'h0000}, // R7
    '{4'd6, 4'b1000, 16'hFFFF, 16'h0001, 16'h0000}, // R6
    '{4'd6, 4'b1000, 16'h00FF, 16'h0001, 16'h0100}, // R6
    '{4'd2, 4'b0100, 16'h0FFF, 16'h0001, 16'h0000}, // R2
    '{4'd4, 4'b0010, 16'h000F, 16'h0001, 16'h0010}, // R4
    '{4'd2, 4'b0101, 16'h0FFF, 16'h0011, 16'h0000}, // R2
    '{4'd2, 4'b0110, 16'hFFFF, 16'h0101, 16'hF000}, // R2
    '{4'd6, 4'b1111, 16'hFFFF, 16'h0001, 16'hFFF0}  // R6
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [M-1:0] cut = '0;
  logic [W-1:0] sum;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  part_mask_adder #(.W(W), .M(M)) uut (.a(a), .b(b), .lane_cut(cut), .sum(sum));

  function automatic logic [W-1:0] model(logic [W-1:0] x, logic [W-1:0] y, logic [M-1:0] c);
    logic [W-1:0] r = '0;
    logic cy = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (k > 0 && k % M == 0 && c[k/M - 1]) cy = 1'b0;
      r[k] = x[k] ^ y[k] ^ cy;
      cy = (x[k] & y[k]) | (x[k] & cy) | (y[k] & cy);
    end
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] exp);
    total++;
    if (sum !== exp) begin
      bad++;
      $display("FAIL %s: cut=%b a=%h b=%h got=%h exp=%h", tag, cut, a, b, sum, exp);
    end
  endtask

  task automatic apply(logic [M-1:0] c, logic [W-1:0] x, logic [W-1:0] y);
    @(negedge clk);
    cut = c; a = x; b = y;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog: got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 reset-state zero inputs", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].cut, VEC[i].a, VEC[i].b);
      check($sformatf("R%0d table row %0d", VEC[i].req, i), VEC[i].y);
    end

    for (int c = 0; c < 16; c++) begin
      apply(4'(c), 16'hFFFF, 16'h1111);
      check("R3 R5 ones plus lane-bottom ones", model(16'hFFFF, 16'h1111, 4'(c)));
      apply(4'(c), 16'hFFFF, 16'h0001);
      check("R4 ripple from bit 0", model(16'hFFFF, 16'h0001, 4'(c)));
      apply(4'(c), 16'hAAAA, 16'h5556);
      check("R2 alternating bits", model(16'hAAAA, 16'h5556, 4'(c)));
      apply(4'(c), 16'h0F0F, 16'h1010);
      check("R5 no carries", model(16'h0F0F, 16'h1010, 4'(c)));
      total++;
      if (model(16'hFFFF, 16'h1111, 4'(c)) !== model(16'hFFFF, 16'h1111, 4'(c) ^ 4'b1000)) begin
        bad++;
        $display("FAIL R6 model self-check: cut=%0d got=diff exp=same", c);
      end
    end

    for (int c = 0; c < 8; c++) begin
      apply(4'(c), 16'h7FFF, 16'h8889);
      check("R6 top bit clear", model(16'h7FFF, 16'h8889, 4'(c)));
      apply(4'(c) | 4'b1000, 16'h7FFF, 16'h8889);
      check("R6 top bit set", model(16'h7FFF, 16'h8889, 4'(c)));
    end

    apply(4'b0000, 16'h0FFF, 16'h0001);
    check("R8 same operands full width", 16'h1000);
    cut = 4'b0100;
    #1;
    check("R8 cut change without clock", 16'h0000);
    cut = 4'b0000;
    #1;
    check("R8 cut restored no history", 16'h1000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule